// File: doc/BRIEF.md
# Accelerator Performance Counter Unit

This block watches a streaming accelerator from the outside and measures each run. It sees the accelerator's start pulse, its done indication, and the valid/ready handshakes of its input and output streams. It counts three quantities: the clock cycles the accelerator is busy, the input tokens accepted and the output tokens emitted. None of these counts depend on the kernel the accelerator computes. The host reads the counts through the same small memory-mapped register port that it uses to configure the accelerator.

Software can also program an expected run length in cycles and an expected number of output tokens. A watchdog compares the live counts with these targets. A run is declared stalled when it has been busy for at least three times the expected cycle count and has still produced fewer output tokens than expected. The unit then raises a sticky stall flag and a one-cycle restart request for the host or the local reset logic.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every readable register returns zero and `restart_req` is low.
- R2: A cycle with `acc_start` high clears all three counters, the done flag and the stall flag on the next edge and marks the unit busy. A start while a run is in progress restarts the run.
- R3: The cycle counter increments once for every clock edge at which the unit is busy. This includes the edge at which `acc_done` ends the run. The start edge is not counted.
- R4: The input token counter increments only on a busy edge at which `in_valid` and `in_ready` are both high.
- R5: The output token counter increments only on a busy edge at which `out_valid` and `out_ready` are both high.
- R6: Once `acc_done` has ended a run, all counters hold their values until the next start, whatever the handshake inputs do. `acc_done` while idle has no effect.
- R7: Each counter stops at its all-ones value (CNT_W bits) and does not wrap.
- R8: Word offsets: 0x00 cycle count, 0x04 input tokens, 0x08 output tokens, 0x0C expected cycles, 0x10 expected output tokens, 0x14 status. Status bit 0 is done and bit 1 is stall; the other bits are zero. Counters read zero-extended. Unaligned or unmapped addresses read zero. Writes to them, and writes to the counter or status offsets, change nothing.
- R9: The registers at 0x0C and 0x10 hold the full 32-bit value written on a `reg_wen` cycle and read it back on the next cycle.
- R10: The stall flag sets on the edge after a busy cycle that meets all of these: the expected cycle value is nonzero, the cycle count is at least three times that value, the output token count is below the expected output tokens, and there is no start. The flag stays set until the next start, including after done.
- R11: `restart_req` is high for exactly one cycle, the cycle in which the stall flag first becomes set.
- R12: An expected cycle value of zero disables the watchdog. A run that has reached its expected output token count is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_start | input | 1 | Accelerator run start pulse |
| acc_done | input | 1 | Accelerator run completion |
| in_valid | input | 1 | Input stream valid |
| in_ready | input | 1 | Input stream ready |
| out_valid | input | 1 | Output stream valid |
| out_ready | input | 1 | Output stream ready |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wen | input | 1 | Register write enable |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| restart_req | output | 1 | One-cycle restart request on stall |

## Verification
The bench drives runs with several handshake patterns. Input and output streams are given different duty cycles, so a swapped or wrongly gated token counter shows up. Ready is sometimes held low while valid is high, which separates a handshake count from a plain valid count. One run is tuned to stall and then finish, which tests stickiness and the single-cycle request. Two further runs must not stall: one with the watchdog disabled and one that delivers enough output. A 300-cycle run checks that the narrow counters stop at all-ones. The read address rotates through the whole map every cycle, including an unmapped word, and every value is compared with a behavioural model.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

   typedef enum logic [2:0] {
      W_CYCLES   = 3'd0,
      W_IN_TOK   = 3'd1,
      W_OUT_TOK  = 3'd2,
      W_EXP_CYC  = 3'd3,
      W_EXP_OUT  = 3'd4,
      W_STATUS   = 3'd5
   } reg_word_e;

   localparam int ST_DONE_BIT  = 0;
   localparam int ST_STALL_BIT = 1;

   localparam int NUM_EVENTS = 3;
   localparam int EV_CYCLES  = 0;
   localparam int EV_IN      = 1;
   localparam int EV_OUT     = 2;

   typedef struct packed {
      logic stall;
      logic done;
   } run_status_t;

endpackage

// File: rtl/perf_run_ctrl.sv
module perf_run_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy,
   output logic done_flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done_flag <= 1'b0;
      end else if (start) begin
         busy      <= 1'b1;
         done_flag <= 1'b0;
      end else if (done && busy) begin
         busy      <= 1'b0;
         done_flag <= 1'b1;
      end
   end

   // R2: start opens a run with a cleared done flag
   a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !done_flag));

   // R3: done closes the run
   a_r3_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done && !start) |=> (!busy && done_flag));

   // R6: done while idle has no effect
   a_r6_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> (!busy && $stable(done_flag)));

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] MAXV = '1;
   localparam logic [W-1:0] ONE  = W'(1);

   generate
      if (W < 1 || W > 32) begin : g_bad_width
         $error("perf_event_counter: W must lie in 1..32");
      end

      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 q <= '0;
            else if (clr)               q <= '0;
            else if (inc && q != MAXV)  q <= q + ONE;
         end

         // R7: an all-ones counter stays there
         a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (q == MAXV && !clr) |=> (q == MAXV));
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= '0;
            else if (clr)    q <= '0;
            else if (inc)    q <= q + ONE;
         end
      end
   endgenerate

   // R2: clear wins
   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));

   // R6: no event, no change
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(q));

endmodule

// File: rtl/perf_stall_watch.sv
module perf_stall_watch #(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              busy,
   input  logic [CNT_W-1:0]  cyc_cnt,
   input  logic [CNT_W-1:0]  out_cnt,
   input  logic [DATA_W-1:0] exp_cyc,
   input  logic [DATA_W-1:0] exp_out,
   output logic              stall,
   output logic              restart_req
);

   localparam int LIM_W = DATA_W + 2;

   logic [LIM_W-1:0]  limit;
   logic [LIM_W-1:0]  cyc_ext;
   logic [DATA_W-1:0] out_ext;
   logic              fire;

   generate
      if (CNT_W > DATA_W) begin : g_bad_width
         $error("perf_stall_watch: CNT_W must not exceed DATA_W");
      end
   endgenerate

   always_comb begin
      limit   = {2'b00, exp_cyc} + {1'b0, exp_cyc, 1'b0};
      cyc_ext = '0;
      cyc_ext[CNT_W-1:0] = cyc_cnt;
      out_ext = '0;
      out_ext[CNT_W-1:0] = out_cnt;
      fire = busy && !start && !stall && (exp_cyc != '0)
             && (cyc_ext >= limit) && (out_ext < exp_out);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall       <= 1'b0;
         restart_req <= 1'b0;
      end else if (start) begin
         stall       <= 1'b0;
         restart_req <= 1'b0;
      end else begin
         restart_req <= fire;
         if (fire) stall <= 1'b1;
      end
   end

   // R10: sticky until next start
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !start) |=> stall);

   // R11: request lasts a single cycle
   a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !restart_req);

   // R11: request only with a freshly set flag
   a_r11_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restart_req) |-> $rose(stall));

   // R12: disabled watchdog never sets the flag
   a_r12_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && exp_cyc == '0) |=> !stall);

endmodule

// File: rtl/perf_reg_bank.sv
module perf_reg_bank
   import perf_mon_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [CNT_W-1:0]  cnt_cycles,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic [CNT_W-1:0]  cnt_out,
   input  run_status_t       status,
   output logic [DATA_W-1:0] exp_cyc,
   output logic [DATA_W-1:0] exp_out,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam int WORD_W = ADDR_W - 2;

   logic              aligned;
   logic [WORD_W-1:0] word;
   logic              hit_exp_cyc;
   logic              hit_exp_out;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("perf_reg_bank: ADDR_W must be at least 5");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("perf_reg_bank: DATA_W must be at least 2");
      end
   endgenerate

   assign aligned     = (reg_addr[1:0] == 2'b00);
   assign word        = reg_addr[ADDR_W-1:2];
   assign hit_exp_cyc = aligned && (word == WORD_W'(W_EXP_CYC));
   assign hit_exp_out = aligned && (word == WORD_W'(W_EXP_OUT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_cyc <= '0;
         exp_out <= '0;
      end else if (reg_wen) begin
         if (hit_exp_cyc) exp_cyc <= reg_wdata;
         if (hit_exp_out) exp_out <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (aligned) begin
         if (word == WORD_W'(W_CYCLES))       reg_rdata[CNT_W-1:0] = cnt_cycles;
         else if (word == WORD_W'(W_IN_TOK))  reg_rdata[CNT_W-1:0] = cnt_in;
         else if (word == WORD_W'(W_OUT_TOK)) reg_rdata[CNT_W-1:0] = cnt_out;
         else if (word == WORD_W'(W_EXP_CYC)) reg_rdata = exp_cyc;
         else if (word == WORD_W'(W_EXP_OUT)) reg_rdata = exp_out;
         else if (word == WORD_W'(W_STATUS)) begin
            reg_rdata[ST_DONE_BIT]  = status.done;
            reg_rdata[ST_STALL_BIT] = status.stall;
         end
      end
   end

   // R9: expected registers change only on a write
   a_r9_hold_cyc: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wen |=> $stable(exp_cyc));
   a_r9_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wen |=> $stable(exp_out));

   // R8: unaligned access reads zero
   a_r8_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0));

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
   import perf_mon_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_start,
   input  logic              acc_done,
   input  logic              in_valid,
   input  logic              in_ready,
   input  logic              out_valid,
   input  logic              out_ready,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              restart_req
);

   logic                 busy;
   logic                 done_flag;
   logic                 stall;
   logic [NUM_EVENTS-1:0] ev_inc;
   logic [CNT_W-1:0]     cnt [NUM_EVENTS];
   logic [DATA_W-1:0]    exp_cyc;
   logic [DATA_W-1:0]    exp_out;
   run_status_t          status;

   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("perf_mon_unit: CNT_W must lie in 1..DATA_W");
      end
   endgenerate

   perf_run_ctrl u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (acc_start),
      .done      (acc_done),
      .busy      (busy),
      .done_flag (done_flag)
   );

   always_comb begin
      ev_inc            = '0;
      ev_inc[EV_CYCLES] = busy;
      ev_inc[EV_IN]     = busy && in_valid && in_ready;
      ev_inc[EV_OUT]    = busy && out_valid && out_ready;
   end

   for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_ev
      perf_event_counter #(
         .W        (CNT_W),
         .SATURATE (SATURATE)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (acc_start),
         .inc   (ev_inc[e]),
         .q     (cnt[e])
      );
   end

   perf_stall_watch #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (acc_start),
      .busy        (busy),
      .cyc_cnt     (cnt[EV_CYCLES]),
      .out_cnt     (cnt[EV_OUT]),
      .exp_cyc     (exp_cyc),
      .exp_out     (exp_out),
      .stall       (stall),
      .restart_req (restart_req)
   );

   assign status.done  = done_flag;
   assign status.stall = stall;

   perf_reg_bank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_wen    (reg_wen),
      .reg_wdata  (reg_wdata),
      .cnt_cycles (cnt[EV_CYCLES]),
      .cnt_in     (cnt[EV_IN]),
      .cnt_out    (cnt[EV_OUT]),
      .status     (status),
      .exp_cyc    (exp_cyc),
      .exp_out    (exp_out),
      .reg_rdata  (reg_rdata)
   );

   // R4: input tokens only on a busy handshake
   a_r4_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_start && !(busy && in_valid && in_ready)) |=> $stable(cnt[EV_IN]));

   // R5: output tokens only on a busy handshake
   a_r5_out_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_start && !(busy && out_valid && out_ready)) |=> $stable(cnt[EV_OUT]));

   // R6: frozen counters after a finished run
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !acc_start) |=> $stable(cnt[EV_CYCLES]));

endmodule

// File: tb/test_perf_mon_unit.sv
module test_perf_mon_unit;

   localparam int AW = 5;
   localparam int DW = 32;
   localparam int CW = 8;
   localparam longint CMAX = (64'd1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_start = 1'b0, acc_done = 1'b0;
   logic          in_valid = 1'b0, in_ready = 1'b0;
   logic          out_valid = 1'b0, out_ready = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wen = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          restart_req;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   // behavioural reference
   longint m_cyc = 0, m_in = 0, m_out = 0, m_xc = 0, m_xo = 0;
   bit     m_busy = 0, m_done = 0, m_stall = 0, m_rq = 0;

   always #4 clk = ~clk;

   perf_mon_unit #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .SATURATE(1'b1)) i_perf_mon_unit (
      .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_done(acc_done),
      .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
      .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .restart_req(restart_req));

   function automatic longint sat(longint v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cyc = 0; m_in = 0; m_out = 0; m_xc = 0; m_xo = 0;
         m_busy = 0; m_done = 0; m_stall = 0; m_rq = 0;
      end else begin
         if (reg_wen && reg_addr == 5'h0C) m_xc = reg_wdata;
         if (reg_wen && reg_addr == 5'h10) m_xo = reg_wdata;
         if (acc_start) begin
            m_cyc = 0; m_in = 0; m_out = 0;
            m_busy = 1; m_done = 0; m_stall = 0; m_rq = 0;
         end else begin
            m_rq = 0;
            if (m_busy && m_xc != 0 && !m_stall && m_cyc >= 3 * m_xc && m_out < m_xo) begin
               m_stall = 1; m_rq = 1;
            end
            if (m_busy) begin
               m_cyc = sat(m_cyc + 1);
               if (in_valid && in_ready)   m_in  = sat(m_in + 1);
               if (out_valid && out_ready) m_out = sat(m_out + 1);
               if (acc_done) begin m_busy = 0; m_done = 1; end
            end
         end
      end
   end

   function automatic longint exp_rd(logic [AW-1:0] a);
      case (a)
         5'h00: return m_cyc;
         5'h04: return m_in;
         5'h08: return m_out;
         5'h0C: return m_xc;
         5'h10: return m_xo;
         5'h14: return {m_stall, m_done};
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(logic [AW-1:0] a);
      case (a)
         5'h00: return "R3";
         5'h04: return "R4";
         5'h08: return "R5";
         5'h0C, 5'h10: return "R9";
         5'h14: return "R10";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(tag_of(reg_addr), longint'(reg_rdata), exp_rd(reg_addr));
         chk("R11", longint'(restart_req), longint'(m_rq));
      end
   end

   int scan = 0;
   task automatic step();
      @(negedge clk); #1;
      reg_addr = AW'(scan * 4);
      scan = (scan + 1) % 8;
   endtask

   task automatic rd(logic [AW-1:0] a, output longint v);
      reg_addr = a; #1; v = longint'(reg_rdata);
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk); #1;
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk); #1;
      reg_wen = 1'b0;
   endtask

   // len busy edges; ip/op = handshake period (0 = none); rstall holds ready low every 4th cycle
   task automatic run(int len, int ip, int op, bit rgap);
      step(); acc_start = 1'b1;
      step(); acc_start = 1'b0;
      for (int k = 0; k < len; k++) begin
         in_valid  = (ip != 0) && (k % ip == 0);
         in_ready  = !(rgap && (k % 4 == 3));
         out_valid = (op != 0) && (k % op == 0);
         out_ready = !(rgap && (k % 4 == 1));
         acc_done  = (k == len - 1);
         if (k < len - 1) step();
      end
      step();
      acc_done = 1'b0; in_valid = 1'b0; out_valid = 1'b0;
   endtask

   initial begin
      longint v, v2;
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int a = 0; a < 8; a++) begin rd(AW'(a * 4), v); chk("R1", v, 0); end
      chk("R1", longint'(restart_req), 0);
      rst_n = 1'b1;
      wr(5'h0C, 32'd20);
      wr(5'h10, 32'd5);
      rd(5'h0C, v); chk("R9", v, 20);
      wr(5'h10, 32'hDEAD_BEEF);
      rd(5'h10, v); chk("R9", v, 32'hDEAD_BEEF);
      wr(5'h10, 32'd5);
      // run with mixed patterns and ready gaps
      run(15, 2, 3, 1'b1);
      rd(5'h00, v); chk("R3", v, 15);
      rd(5'h04, v); chk("R4", v, m_in);
      rd(5'h14, v); chk("R10", v, 1);
      // R6: counters hold while idle handshakes and a stray done occur
      in_valid = 1; in_ready = 1; out_valid = 1; out_ready = 1; acc_done = 1;
      repeat (10) step();
      in_valid = 0; out_valid = 0; acc_done = 0;
      rd(5'h00, v); chk("R6", v, 15);
      rd(5'h08, v2); chk("R6", v2, m_out);
      // R8: writes to read-only and unmapped words are ignored
      wr(5'h00, 32'd99); wr(5'h14, 32'd3); wr(5'h18, 32'd7); wr(5'h0D, 32'd1);
      rd(5'h00, v); chk("R8", v, 15);
      rd(5'h18, v); chk("R8", v, 0);
      rd(5'h0D, v); chk("R8", v, 0);
      rd(5'h0C, v); chk("R8", v, 20);
      // R10/R11: stall run, then done
      wr(5'h0C, 32'd4); wr(5'h10, 32'd10);
      run(25, 1, 8, 1'b0);
      rd(5'h14, v); chk("R10", v, 3);
      repeat (3) step();
      rd(5'h14, v); chk("R10", v, 3);
      // R2: a new start clears everything
      step(); acc_start = 1'b1;
      step(); acc_start = 1'b0;
      rd(5'h00, v); chk("R2", v, 0);
      rd(5'h14, v); chk("R2", v, 0);
      repeat (5) step();
      run(6, 1, 1, 1'b0);        // restart while busy
      rd(5'h00, v); chk("R2", v, 6);
      // R12: disabled watchdog, then satisfied output count
      wr(5'h0C, 32'd0); wr(5'h10, 32'd50);
      run(40, 0, 0, 1'b0);
      rd(5'h14, v); chk("R12", v, 1);
      wr(5'h0C, 32'd2); wr(5'h10, 32'd3);
      run(30, 2, 1, 1'b0);
      rd(5'h14, v); chk("R12", v, 1);
      // R7: saturation
      wr(5'h0C, 32'd0);
      run(300, 1, 1, 1'b0);
      rd(5'h00, v); chk("R7", v, CMAX);
      rd(5'h04, v); chk("R7", v, CMAX);
      repeat (8) step();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule